// File: doc/BRIEF.md
# Parallel ADC Result Reader

This block sits on the host side of a parallel-bus successive-approximation converter and fetches one 12-bit conversion result per request. On a start request it waits until the converter's busy line is low. It then drives the active-low chip-select and read strobes for a fixed number of system clock cycles. It captures the bus on the clock edge that raises the read strobe.

Two transfer types are supported, chosen by a mode input that is sampled when each sequence begins. In word mode a single strobe returns all twelve result bits. In byte mode the reader makes two strobes. The first, with the high-byte-enable output at 0, fetches the eight low result bits. The second, with high-byte-enable at 1, fetches the four high result bits, a 2-bit channel number and two bits that must read as zero. The reader joins the two bytes into one result and reports the channel. A one-cycle valid pulse marks each finished result. A framing-error pulse accompanies it whenever either must-be-zero bit was set.

The strobe low time and the idle gap between strobes are parameters counted in clock cycles. Both have a floor of one cycle, which gives the converter time to release the bus. A request that arrives while a sequence is running is held and served when that sequence ends.

Top module: `adc_par_reader`

## Requirements
- R1: While reset is high and in the cycle after it falls, cs_n and rd_n are 1, and hben, valid and frame_err are 0.
- R2: In word mode a sequence makes exactly one strobe. result equals db_in[11:0] as sampled on the clock edge at which rd_n rises. chan_id is 0 and frame_err is 0.
- R3: In byte mode a sequence makes exactly two strobes. result[7:0] is db_in[7:0] from the strobe with hben=0. result[11:8] is db_in[3:0] and chan_id is db_in[5:4] from the following strobe with hben=1. db_in[11:8] is ignored in byte mode.
- R4: The first strobe of a sequence begins only on a clock edge at which busy is sampled low. No strobe starts while busy is high.
- R5: rd_n stays low for exactly LOW_CYC clock cycles per strobe (minimum 1), and cs_n is low whenever rd_n is low.
- R6: rd_n stays high for at least GAP_CYC clock cycles (minimum 1) between any two strobes.
- R7: hben is constant throughout each strobe and is 0 for every word-mode strobe.
- R8: valid is high for exactly one cycle per sequence, starting the cycle after the final byte is captured. result and chan_id hold their values until the next completion.
- R9: frame_err is high together with valid when db_in[7] or db_in[6] was 1 on the hben=1 strobe. Otherwise it is 0.
- R10: A start seen while a sequence is running is held pending, and exactly one further sequence follows. Several such starts merge into one.
- R11: word_mode is sampled when a sequence starts. Changing it during the sequence does not alter that sequence's strobe count or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 = one 12-bit read, 0 = two 8-bit reads |
| start | input | 1 | Request one result (single-cycle pulse) |
| busy | input | 1 | Converter busy, high while converting |
| db_in | input | 12 | Converter data bus |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| hben | output | 1 | High-byte enable for byte mode |
| result | output | 12 | Assembled conversion result |
| chan_id | output | 2 | Channel number of the result |
| valid | output | 1 | One-cycle pulse: result ready |
| frame_err | output | 1 | Must-be-zero high-byte bits were set |

## Verification
The assertions take for granted that busy stays low from the moment the first strobe begins until the sequence ends. The second byte read does not look at busy again. They also take start to be a synchronous single-cycle pulse. The stimulus changes inputs shortly after the rising clock edge, drops busy before any read, and holds it low until valid has been seen. The converter model in the bench drives all ones whenever a strobe is inactive, so a capture outside the strobe window shows up as a wrong result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int RES_W = 12;
  localparam int LO_W  = 8;
  localparam int ID_W  = 2;
  localparam int HI_W  = RES_W - LO_W;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_STRB,
    S_GAP
  } rd_state_t;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5 / R6: the window counter steps down by one when not reloaded
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int LOW_CYC = 3,
  parameter int GAP_CYC = 2,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          busy,
  input  logic          word_mode,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cs_n,
  output logic          rd_n,
  output logic          hben,
  output logic          cap,
  output logic          cap_hi,
  output logic          cap_last,
  output logic          mode_q
);
  localparam int LOW_EFF = (LOW_CYC < 1) ? 1 : LOW_CYC;
  localparam int GAP_EFF = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam logic [CW-1:0] LOW_V = CW'(LOW_EFF - 1);
  localparam logic [CW-1:0] GAP_V = CW'(GAP_EFF - 1);

  rd_state_t state;
  logic      phase;
  logic      pend;
  logic      byte_first;

  assign byte_first = !mode_q && !phase;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = LOW_V;
    case (state)
      S_WAIT: tmr_load = !busy;
      S_STRB: begin
        tmr_load = tmr_zero;
        tmr_val  = GAP_V;
      end
      S_GAP:  tmr_load = tmr_zero && byte_first;
      default: tmr_load = 1'b0;
    endcase
  end

  assign cap      = (state == S_STRB) && tmr_zero;
  assign cap_hi   = phase;
  assign cap_last = mode_q || phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      phase  <= 1'b0;
      pend   <= 1'b0;
      mode_q <= 1'b1;
      cs_n   <= 1'b1;
      rd_n   <= 1'b1;
      hben   <= 1'b0;
    end else begin
      if (start && state != S_IDLE)
        pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (start || pend) begin
            pend   <= 1'b0;
            state  <= S_WAIT;
            mode_q <= word_mode;
            phase  <= 1'b0;
            hben   <= 1'b0;
          end
        end
        S_WAIT: begin
          if (!busy) begin
            state <= S_STRB;
            cs_n  <= 1'b0;
            rd_n  <= 1'b0;
          end
        end
        S_STRB: begin
          if (tmr_zero) begin
            state <= S_GAP;
            cs_n  <= 1'b1;
            rd_n  <= 1'b1;
            if (byte_first)
              hben <= 1'b1;
          end
        end
        S_GAP: begin
          if (tmr_zero) begin
            if (byte_first) begin
              phase <= 1'b1;
              state <= S_STRB;
              cs_n  <= 1'b0;
              rd_n  <= 1'b0;
            end else begin
              state <= S_IDLE;
              phase <= 1'b0;
              hben  <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a first strobe only opens after busy was seen low
  a_r4_no_read_busy: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) && !phase) |-> !$past(busy));

  // R7: high-byte enable does not move inside a strobe
  a_r7_hben_steady: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n)) |-> $stable(hben));

  // R5: chip select covers every read strobe
  a_r5_cs_covers_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n);
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             cap_hi,
  input  logic             cap_last,
  input  logic             mode_q,
  input  logic [RES_W-1:0] db,
  output logic [RES_W-1:0] result,
  output logic [ID_W-1:0]  chan_id,
  output logic             valid,
  output logic             frame_err
);
  localparam int ID_LSB = HI_W;
  localparam int Z_LSB  = HI_W + ID_W;

  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      result    <= '0;
      chan_id   <= '0;
      valid     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      valid     <= 1'b0;
      frame_err <= 1'b0;
      if (cap) begin
        if (mode_q) begin
          result  <= db;
          chan_id <= '0;
          valid   <= 1'b1;
        end else if (!cap_hi) begin
          lo_q <= db[LO_W-1:0];
        end else begin
          result    <= {db[HI_W-1:0], lo_q};
          chan_id   <= db[ID_LSB +: ID_W];
          frame_err <= |db[LO_W-1:Z_LSB];
          valid     <= cap_last;
        end
      end
    end
  end

  // R8: the completion pulse never lasts two cycles
  a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R9: framing error appears only with a completion
  a_r9_ferr_with_valid: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> valid);

  // R8: result holds between completions
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(result));
endmodule

// File: rtl/adc_par_reader.sv
module adc_par_reader
  import adc_rd_pkg::*;
#(
  parameter int LOW_CYC = 3,
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             start,
  input  logic             busy,
  input  logic [RES_W-1:0] db_in,
  output logic             cs_n,
  output logic             rd_n,
  output logic             hben,
  output logic [RES_W-1:0] result,
  output logic [ID_W-1:0]  chan_id,
  output logic             valid,
  output logic             frame_err
);
  localparam int MAXC = (LOW_CYC > GAP_CYC) ? LOW_CYC : GAP_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          cap;
  logic          cap_hi;
  logic          cap_last;
  logic          mode_q;

  adc_rd_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  adc_rd_seq #(.LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .word_mode (word_mode),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .hben      (hben),
    .cap       (cap),
    .cap_hi    (cap_hi),
    .cap_last  (cap_last),
    .mode_q    (mode_q)
  );

  adc_rd_assemble u_asm (
    .clk       (clk),
    .rst       (rst),
    .cap       (cap),
    .cap_hi    (cap_hi),
    .cap_last  (cap_last),
    .mode_q    (mode_q),
    .db        (db_in),
    .result    (result),
    .chan_id   (chan_id),
    .valid     (valid),
    .frame_err (frame_err)
  );

  // R7: word-mode strobes keep the high-byte enable low
  a_r7_word_hben_low: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && mode_q) |-> !hben);
endmodule

// File: tb/adc_par_reader_bench.sv
module adc_par_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_CYC = 3;
  localparam int GAP_CYC = 2;
  localparam int NV = 8;
  // {mode, busy cycles, value, channel, zero bits}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd3,  12'hABC, 2'd0, 2'b00},
    {1'b0, 8'd5,  12'h123, 2'd2, 2'b00},
    {1'b0, 8'd0,  12'hFFF, 2'd3, 2'b00},
    {1'b0, 8'd10, 12'h000, 2'd0, 2'b01},
    {1'b1, 8'd0,  12'h000, 2'd0, 2'b00},
    {1'b0, 8'd2,  12'h5A5, 2'd1, 2'b10},
    {1'b1, 8'd40, 12'h800, 2'd0, 2'b00},
    {1'b0, 8'd1,  12'h07F, 2'd1, 2'b00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_mode = 1'b1;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic [11:0] db_in;
  logic cs_n, rd_n, hben, valid, frame_err;
  logic [11:0] result;
  logic [1:0] chan_id;

  logic        cur_mode = 1'b1;
  logic [11:0] cur_val = '0;
  logic [1:0]  cur_ch = '0;
  logic [1:0]  cur_bad = '0;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_par_reader #(.LOW_CYC(LOW_CYC), .GAP_CYC(GAP_CYC)) u_adc_par_reader (
    .clk(clk), .rst(rst), .word_mode(word_mode), .start(start), .busy(busy),
    .db_in(db_in), .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .result(result),
    .chan_id(chan_id), .valid(valid), .frame_err(frame_err)
  );

  // converter model: bus floats to all ones outside a strobe
  assign db_in = (!cs_n && !rd_n) ?
                 (cur_mode ? cur_val :
                  (hben ? {4'hA, cur_bad, cur_ch, cur_val[11:8]}
                        : {4'h5, cur_val[7:0]}))
                 : 12'hFFF;

  // monitor of strobe shape, busy rule and pulse counts
  int  rd_total = 0, v_total = 0, mon_err = 0;
  int  lowcnt = 0, highcnt = 0;
  logic prev_rd = 1'b1, prev_busy = 1'b0, prev_valid = 1'b0, seen_rd = 1'b0;
  logic hb_first = 1'b0, hb_last = 1'b0, hb_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!rd_n) begin
        if (prev_rd) begin
          if (seen_rd && highcnt < GAP_CYC) mon_err++;
          if (prev_busy) mon_err++;
          hb_first = hben;
          lowcnt = 0;
        end
        if (hben != hb_first) mon_err++;
        if (cs_n) mon_err++;
        lowcnt++;
      end else begin
        if (!prev_rd) begin
          if (lowcnt != LOW_CYC) mon_err++;
          rd_total++;
          hb_prev = hb_last;
          hb_last = hb_first;
          seen_rd = 1'b1;
          highcnt = 0;
        end
        highcnt++;
      end
      if (valid) v_total++;
      if (valid && prev_valid) mon_err++;
      prev_valid = valid;
    end
    prev_rd = rd_n;
    prev_busy = busy;
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic m, input int bc, input logic [11:0] v,
                         input logic [1:0] ch, input logic [1:0] bad,
                         input logic flip);
    int r0, v0, e0;
    logic [11:0] got_r;
    logic [1:0]  got_c;
    logic        got_f;
    logic        seen;
    int          exp_reads;
    r0 = rd_total; v0 = v_total; e0 = mon_err;
    got_r = '0; got_c = '0; got_f = 1'b0; seen = 1'b0;
    @(posedge clk); #2;
    cur_mode = m; cur_val = v; cur_ch = ch; cur_bad = bad;
    word_mode = m; busy = 1'b1; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (bc) @(posedge clk);
    #2 busy = 1'b0;
    if (flip) begin
      @(posedge rd_n); #2 word_mode = ~m;
    end
    for (int i = 0; i < 500 && !seen; i++) begin
      @(negedge clk);
      if (valid) begin
        seen = 1'b1; got_r = result; got_c = chan_id; got_f = frame_err;
      end
    end
    repeat (GAP_CYC + 6) @(posedge clk);
    exp_reads = m ? 1 : 2;
    if (m) begin
      check("R2 result", got_r, v);
      check("R2 chan_id", got_c, 0);
      check("R2 frame_err", got_f, 0);
    end else begin
      check("R3 result", got_r, v);
      check("R3 chan_id", got_c, ch);
      check("R9 frame_err", got_f, (bad != 2'b00) ? 1 : 0);
      check("R3 hben order", {hb_prev, hb_last}, 2'b01);
    end
    check(flip ? "R11 strobe count" : "R2/R3 strobe count", rd_total - r0, exp_reads);
    check("R8 valid count", v_total - v0, 1);
    check("R4/R5/R6/R7 strobe rules", mon_err - e0, 0);
    check("R8 result held", result, v);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 cs_n in reset", cs_n, 1);
    check("R1 rd_n in reset", rd_n, 1);
    check("R1 hben/valid/frame_err in reset", {hben, valid, frame_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {cs_n, rd_n, hben, valid, frame_err}, 5'b11000);

    for (int k = 0; k < NV; k++)
      run_seq(VEC[k][24], int'(VEC[k][23:16]), VEC[k][15:4],
              VEC[k][3:2], VEC[k][1:0], 1'b0);

    // R11: mode flipped after the first byte strobe
    run_seq(1'b0, 2, 12'h3C6, 2'd2, 2'b00, 1'b1);
    run_seq(1'b1, 2, 12'h9E1, 2'd0, 2'b00, 1'b1);

    // R10: starts during a sequence merge into one more sequence
    begin
      int r0, v0, e0;
      r0 = rd_total; v0 = v_total; e0 = mon_err;
      @(posedge clk); #2;
      cur_mode = 1'b0; cur_val = 12'h4D2; cur_ch = 2'd3; cur_bad = 2'b00;
      word_mode = 1'b0; busy = 1'b0; start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      repeat (3) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      @(posedge clk); #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      repeat (200) @(posedge clk);
      check("R10 valid count", v_total - v0, 2);
      check("R10 strobe count", rd_total - r0, 4);
      check("R10 strobe rules", mon_err - e0, 0);
      check("R10 result", result, 12'h4D2);
    end

    // R4: busy held high keeps the bus quiet
    begin
      int r0;
      r0 = rd_total;
      @(posedge clk); #2 busy = 1'b1; start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      repeat (60) @(posedge clk);
      check("R4 no strobe while busy", rd_total - r0, 0);
      #2 busy = 1'b0;
      repeat (40) @(posedge clk);
      check("R4 strobe after busy low", rd_total - r0, 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule